// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the multiply-divide unit of a 32-bit integer pipeline. It owns a 64-bit HI:LO register pair and performs signed and unsigned multiplies into the pair, accumulating and subtracting multiplies on the pair, and signed and unsigned divides. A divide leaves the remainder in HI and the quotient in LO. It also performs direct writes of HI or LO from the rs operand, and reads of HI or LO onto a result port. A separate three-operand multiply returns only the low word of a signed product on the result port and leaves HI:LO untouched.

The issuer presents an operation code with `rs`/`rt` operands and raises `start_i`. Every operation except divide completes in the cycle it is accepted. A divide is iterative and produces one quotient bit per cycle, with `busy_o` high while it runs. A request that reads or writes HI:LO during a divide is held off with `stall_o`. The issuer keeps the request steady until `stall_o` falls, and the request is then accepted. The three-operand multiply never touches HI:LO, so it is accepted even while a divide runs.

Top module: `hilo_muldiv`

## Requirements
- R1: After reset, HI and LO read as zero and `busy_o`, `stall_o` and `res_valid_o` are low.
- R2: Opcodes 0 (signed) and 1 (unsigned) write the 64-bit product rs×rt into HI:LO, upper word to HI and lower word to LO.
- R3: Opcodes 4/5 (signed/unsigned) add the product rs×rt to the 64-bit value HI:LO. Opcodes 6/7 subtract it. Carries and borrows cross from LO into HI, and the sum or difference is written back to HI:LO.
- R4: Opcodes 2 (signed) and 3 (unsigned) divide rs by rt and leave the quotient in LO and the remainder in HI. Signed quotients truncate toward zero and the remainder carries the dividend's sign. 0x80000000 divided by 0xFFFFFFFF signed gives LO=0x80000000 and HI=0.
- R5: A divide by zero completes without fault and leaves LO=0xFFFFFFFF and HI=rs.
- R6: An accepted divide holds `busy_o` high for exactly 32 cycles. HI:LO take the divide result at the clock edge where `busy_o` falls.
- R7: Opcodes 9 (read HI), 10 (read LO) and 8 (three-operand multiply) drive `res_o` and pulse `res_valid_o` for one cycle in the cycle after acceptance. No other opcode raises `res_valid_o`.
- R8: Opcode 11 copies rs into HI and opcode 12 copies rs into LO, each leaving the other half unchanged.
- R9: A request with any opcode in 0..7 or 9..12 made while `busy_o` is high raises `stall_o` and is not acted on. It is accepted in the first cycle after `busy_o` falls, so a read issued during a divide returns the divide's result.
- R10: Opcode 8 writes the low 32 bits of the signed product rs×rt to `res_o`. It is accepted even while a divide runs and never changes HI or LO.
- R11: Opcodes 13..15, and any cycle with `start_i` low, change neither HI nor LO and raise no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe; held while `stall_o` is high |
| op_i | input | 4 | Operation code (see requirements) |
| rs_i | input | 32 | First operand / dividend / write data |
| rt_i | input | 32 | Second operand / divisor |
| busy_o | output | 1 | Divide in progress |
| stall_o | output | 1 | Current request refused this cycle |
| res_valid_o | output | 1 | `res_o` carries a new value |
| res_o | output | 32 | Read or three-operand multiply result |

## Verification
A three-operand multiply can be accepted in the same cycle that an iterative divide is stepping, and a HI/LO request can be pending in the very cycle the divide writes its result. The bench starts a divide and at once issues a three-operand multiply. It judges that the multiply is not stalled, that its product appears while `busy_o` is still high, and that HI:LO afterwards hold the divide result alone. It also issues a read and a write of HI:LO straight after a divide. It checks that each is stalled for exactly the 32 busy cycles and then sees, or overwrites, the freshly written divide result.

// File: rtl/hilo_pkg.sv
`timescale 1ns/1ps
package hilo_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_MULT  = 4'd0,
    OP_MULTU = 4'd1,
    OP_DIV   = 4'd2,
    OP_DIVU  = 4'd3,
    OP_MADD  = 4'd4,
    OP_MADDU = 4'd5,
    OP_MSUB  = 4'd6,
    OP_MSUBU = 4'd7,
    OP_MUL3  = 4'd8,
    OP_RDHI  = 4'd9,
    OP_RDLO  = 4'd10,
    OP_WRHI  = 4'd11,
    OP_WRLO  = 4'd12
  } mdu_op_e;

  function automatic logic op_known(logic [OP_W-1:0] op);
    return op <= OP_WRLO;
  endfunction

  function automatic logic op_uses_hilo(logic [OP_W-1:0] op);
    return op_known(op) && (op != OP_MUL3);
  endfunction

  function automatic logic op_returns(logic [OP_W-1:0] op);
    return (op == OP_RDHI) || (op == OP_RDLO) || (op == OP_MUL3);
  endfunction

  function automatic logic op_signed_mul(logic [OP_W-1:0] op);
    return (op == OP_MULT) || (op == OP_MADD) || (op == OP_MSUB) || (op == OP_MUL3);
  endfunction

  function automatic logic op_is_div(logic [OP_W-1:0] op);
    return (op == OP_DIV) || (op == OP_DIVU);
  endfunction

  function automatic logic op_is_acc(logic [OP_W-1:0] op);
    return (op == OP_MADD) || (op == OP_MADDU) || (op == OP_MSUB) || (op == OP_MSUBU);
  endfunction

endpackage

// File: rtl/hilo_mac.sv
`timescale 1ns/1ps
module hilo_mac #(
  parameter int W = 32,
  localparam int DW = 2 * W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          sgn_i,
  input  logic          sub_i,
  input  logic [DW-1:0] acc_i,
  output logic [DW-1:0] prod_o,
  output logic [DW-1:0] acc_next_o
);

  function automatic logic [DW-1:0] widen(logic [W-1:0] v, logic s);
    return s ? {{W{v[W-1]}}, v} : {{W{1'b0}}, v};
  endfunction

  function automatic logic [DW-1:0] full_mul(logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic [DW-1:0] wa;
    logic [DW-1:0] wb;
    wa = widen(a, s);
    wb = widen(b, s);
    return wa * wb;
  endfunction

  function automatic logic [DW-1:0] accumulate(logic [DW-1:0] acc, logic [DW-1:0] p, logic sub);
    return sub ? (acc - p) : (acc + p);
  endfunction

  always_comb begin
    prod_o     = full_mul(a_i, b_i, sgn_i);
    acc_next_o = accumulate(acc_i, prod_o, sub_i);
  end

endmodule

// File: rtl/hilo_divider.sv
`timescale 1ns/1ps
module hilo_divider #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         sgn_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q, dvd_q;
  logic          negq_q, negr_q, zero_q;

  logic [W:0]    trial;
  logic          take;
  logic [W-1:0]  rem_n, quo_n;

  function automatic logic [W-1:0] magnitude(logic [W-1:0] v, logic s);
    return (s && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [W-1:0] apply_sign(logic [W-1:0] v, logic neg);
    return neg ? (~v + 1'b1) : v;
  endfunction

  // one restoring step per cycle
  always_comb begin
    trial = {rem_q, quo_q[W-1]} - {1'b0, dvs_q};
    take  = ~trial[W];
    rem_n = take ? trial[W-1:0] : {rem_q[W-2:0], quo_q[W-1]};
    quo_n = {quo_q[W-2:0], take};
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CW'(1));
  assign quo_o  = zero_q ? {W{1'b1}} : apply_sign(quo_n, negq_q);
  assign rem_o  = zero_q ? dvd_q     : apply_sign(rem_n, negr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      dvd_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(W);
      rem_q  <= '0;
      quo_q  <= magnitude(dividend_i, sgn_i);
      dvs_q  <= magnitude(divisor_i, sgn_i);
      dvd_q  <= dividend_i;
      negq_q <= sgn_i && (dividend_i[W-1] ^ divisor_i[W-1]);
      negr_q <= sgn_i && dividend_i[W-1];
      zero_q <= (divisor_i == '0);
    end else if (busy_q) begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      cnt_q  <= cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_q <= 1'b0;
    end
  end

  AST_NO_RELOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_q) else $error("divide restarted while running"); // R9

endmodule

// File: rtl/hilo_muldiv.sv
`timescale 1ns/1ps
module hilo_muldiv
  import hilo_pkg::*;
#(
  parameter int W = 32,
  localparam int DW = 2 * W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    rs_i,
  input  logic [W-1:0]    rt_i,
  output logic            busy_o,
  output logic            stall_o,
  output logic            res_valid_o,
  output logic [W-1:0]    res_o
);

  logic [W-1:0]  hi_q, lo_q, res_q;
  logic          rv_q;
  logic          accept;
  logic          div_busy, div_done, div_load;
  logic [W-1:0]  div_quo, div_rem;
  logic [DW-1:0] prod, acc_next;

  assign stall_o = start_i && div_busy && op_uses_hilo(op_i);
  assign accept  = start_i && op_known(op_i) && !stall_o;
  assign div_load = accept && op_is_div(op_i);

  hilo_mac #(.W(W)) u_mac (
    .a_i        (rs_i),
    .b_i        (rt_i),
    .sgn_i      (op_signed_mul(op_i)),
    .sub_i      ((op_i == OP_MSUB) || (op_i == OP_MSUBU)),
    .acc_i      ({hi_q, lo_q}),
    .prod_o     (prod),
    .acc_next_o (acc_next)
  );

  hilo_divider #(.W(W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (div_load),
    .sgn_i      (op_i == OP_DIV),
    .dividend_i (rs_i),
    .divisor_i  (rt_i),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .quo_o      (div_quo),
    .rem_o      (div_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= '0;
      res_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      rv_q <= accept && op_returns(op_i);
      if (accept) begin
        unique case (op_i)
          OP_RDHI: res_q <= hi_q;
          OP_RDLO: res_q <= lo_q;
          OP_MUL3: res_q <= prod[W-1:0];
          default: ;
        endcase
      end
      if (div_done) begin
        hi_q <= div_rem;
        lo_q <= div_quo;
      end else if (accept) begin
        if ((op_i == OP_MULT) || (op_i == OP_MULTU)) begin
          {hi_q, lo_q} <= prod;
        end else if (op_is_acc(op_i)) begin
          {hi_q, lo_q} <= acc_next;
        end else if (op_i == OP_WRHI) begin
          hi_q <= rs_i;
        end else if (op_i == OP_WRLO) begin
          lo_q <= rs_i;
        end
      end
    end
  end

  assign busy_o      = div_busy;
  assign res_valid_o = rv_q;
  assign res_o       = res_q;

  AST_STALL_HOLDS_HILO: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !div_done) |=> ($stable(hi_q) && $stable(lo_q))) else $error("HI/LO moved under stall"); // R9
  AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !res_valid_o) else $error("result raised for a stalled request"); // R9
  AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(div_done)) else $error("busy fell without divide completion"); // R6
  AST_HILO_WRITE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({hi_q, lo_q}) |-> $past(accept || div_done)) else $error("HI/LO changed with no cause"); // R11

endmodule

// File: tb/test_hilo_muldiv.sv
`timescale 1ns/1ps
module test_hilo_muldiv;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [31:0] rs = '0, rt = '0;
  logic        busy_o, stall_o, res_valid_o;
  logic [31:0] res_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mhi = '0, mlo = '0;

  always #10 clk = ~clk;

  hilo_muldiv i_hilo_muldiv (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op_i), .rs_i(rs), .rt_i(rt),
    .busy_o(busy_o), .stall_o(stall_o), .res_valid_o(res_valid_o), .res_o(res_o)
  );

  localparam int NV = 17;
  localparam logic [67:0] VEC [NV] = '{
    {4'd0,  32'h0000_0007, 32'hFFFF_FFFD},
    {4'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {4'd0,  32'h8000_0000, 32'h8000_0000},
    {4'd4,  32'h0001_0000, 32'h0001_0000},
    {4'd5,  32'hFFFF_FFFF, 32'h0000_0002},
    {4'd6,  32'h0000_0003, 32'h0000_0005},
    {4'd7,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {4'd2,  32'h0000_0007, 32'hFFFF_FFFE},
    {4'd2,  32'hFFFF_FFF9, 32'h0000_0002},
    {4'd3,  32'hFFFF_FFFF, 32'h0000_0010},
    {4'd2,  32'h8000_0000, 32'hFFFF_FFFF},
    {4'd3,  32'h0000_1234, 32'h0000_0000},
    {4'd2,  32'hFFFF_FF00, 32'h0000_0000},
    {4'd11, 32'h0BAD_CAFE, 32'h0000_0001},
    {4'd12, 32'h1234_5678, 32'h0000_0002},
    {4'd8,  32'hFFFF_FFFE, 32'h0000_0003},
    {4'd14, 32'hDEAD_BEEF, 32'h0000_0009}
  };

  function automatic string req_of(logic [3:0] op, logic [31:0] b);
    if (op <= 4'd1) return "R2";
    if (op == 4'd2 || op == 4'd3) return (b == 0) ? "R5" : "R4";
    if (op <= 4'd7) return "R3";
    if (op == 4'd8) return "R10";
    if (op == 4'd11 || op == 4'd12) return "R8";
    return "R11";
  endfunction

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ps, pu, acc;
    int sa, sb;
    ps  = {{32{a[31]}}, a} * {{32{b[31]}}, b};
    pu  = {32'b0, a} * {32'b0, b};
    acc = {mhi, mlo};
    sa = a; sb = b;
    case (op)
      4'd0: {mhi, mlo} = ps;
      4'd1: {mhi, mlo} = pu;
      4'd4: {mhi, mlo} = acc + ps;
      4'd5: {mhi, mlo} = acc + pu;
      4'd6: {mhi, mlo} = acc - ps;
      4'd7: {mhi, mlo} = acc - pu;
      4'd2, 4'd3: begin
        if (b == 0) begin mlo = 32'hFFFF_FFFF; mhi = a; end
        else if (op == 4'd3) begin mlo = a / b; mhi = a % b; end
        else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin mlo = a; mhi = 0; end
        else begin mlo = sa / sb; mhi = sa % sb; end
      end
      4'd11: mhi = a;
      4'd12: mlo = a;
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       output int stalls);
    stalls = 0;
    @(negedge clk);
    start = 1'b1; op_i = op; rs = a; rt = b;
    #1;
    while (stall_o) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    start = 1'b0;
  endtask

  task automatic rd(input logic [3:0] op, output logic [31:0] v, output logic rv, output int stalls);
    issue(op, 32'h0, 32'h0, stalls);
    @(negedge clk);
    v = res_o;
    rv = res_valid_o;
  endtask

  task automatic check_hilo(input string req);
    logic [31:0] v;
    logic rv;
    int s;
    rd(4'd9, v, rv, s);
    chk(req, v, mhi);
    rd(4'd10, v, rv, s);
    chk(req, v, mlo);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R6 run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic rv;
    int s, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", {31'b0, busy_o}, 32'd0);
    chk("R1 stall", {31'b0, stall_o}, 32'd0);
    chk("R1 res_valid", {31'b0, res_valid_o}, 32'd0);
    check_hilo("R1");

    // table walk, every entry followed by HI/LO readback
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op;
      logic [31:0] a, b;
      {op, a, b} = VEC[i];
      issue(op, a, b, s);
      if (op == 4'd8) begin
        @(negedge clk);
        chk("R10 mul3 result", res_o, a * b);
        chk("R7 mul3 valid", {31'b0, res_valid_o}, 32'd1);
      end
      model(op, a, b);
      check_hilo(req_of(op, b));
    end

    // R7: read pulses valid for one cycle only
    rd(4'd9, v, rv, s);
    chk("R7 valid pulse", {31'b0, rv}, 32'd1);
    @(negedge clk);
    chk("R7 valid drops", {31'b0, res_valid_o}, 32'd0);

    // R6: busy span of a divide
    issue(4'd3, 32'd100, 32'd7, s);
    cnt = 0;
    @(negedge clk);
    while (busy_o) begin cnt++; @(negedge clk); end
    chk("R6 busy cycles", cnt, 32);
    model(4'd3, 32'd100, 32'd7);
    check_hilo("R6");

    // R9: read during divide stalls 32 cycles and sees the remainder
    issue(4'd3, 32'd1000, 32'd3, s);
    model(4'd3, 32'd1000, 32'd3);
    rd(4'd9, v, rv, s);
    chk("R9 read stall count", s, 32);
    chk("R9 read after divide", v, 32'd1);

    // R9: write during divide lands after the divide result
    issue(4'd3, 32'd500, 32'd9, s);
    model(4'd3, 32'd500, 32'd9);
    issue(4'd12, 32'd77, 32'd0, s);
    model(4'd12, 32'd77, 32'd0);
    chk("R9 write stall count", s, 32);
    check_hilo("R9");

    // R10: three-operand multiply overlaps a running divide
    issue(4'd3, 32'd50, 32'd5, s);
    model(4'd3, 32'd50, 32'd5);
    issue(4'd8, 32'd6, 32'd7, s);
    chk("R10 no stall", s, 0);
    @(negedge clk);
    chk("R10 product during divide", res_o, 32'd42);
    chk("R10 busy still high", {31'b0, busy_o}, 32'd1);
    check_hilo("R10");

    // R11: start low with a live opcode changes nothing
    @(negedge clk);
    op_i = 4'd0; rs = 32'h1111_1111; rt = 32'h2222_2222;
    repeat (4) @(negedge clk);
    chk("R11 no result", {31'b0, res_valid_o}, 32'd0);
    check_hilo("R11");

    finish_run();
  end

endmodule